// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block sits between a simple synchronous host port and an asynchronous byte-wide static RAM with a 19-bit address. The host raises a request with a direction flag, an address and, for stores, a data byte. The sequencer then plays the strobe sequence the memory needs. It presents a registered address, drops output enable for a load or write enable for a store, and holds each phase for a whole number of clock cycles. Each count is derived from a nanosecond limit and the clock period.

The memory's bidirectional data pins are split into an outbound byte, a drive enable and an inbound byte, so the pad ring owns the tri-state buffer. A load captures the inbound byte on the last cycle of its strobe phase and reports it with a single-cycle valid pulse. A store that closely follows a load is held back until the memory has had time to release the bus. While an access is in flight the block reports busy. A host that raises a request during that time must keep it raised until busy drops.

Top module: `sram_seq`

## Requirements
- R1: While reset is asserted, chip select, write enable and output enable are high (inactive), the drive enable is low, and busy and read-valid are low. From the first clock after reset release, chip select is low and stays low; between accesses write enable and output enable are both high.
- R2: A request is taken at a rising edge only when `req_i` is high and `busy_o` is low. A request raised while busy has no effect: the address on the memory side does not change, and no store is made to the requested location.
- R3: A load holds output enable low and write enable high for RD = max(ceil(85/T), ceil(50/T)) cycles from the accepting edge, where T is the clock period in ns (9 cycles at T=10). Write enable and output enable are never low together.
- R4: The memory address is loaded at the accepting edge and stays unchanged for as long as busy is high.
- R5: A store holds write enable low for WE = max(ceil(65/T), ceil(75/T), ceil(50/T)) cycles (8 at T=10), with output enable high. The drive enable is high exactly while write enable is low, and the outbound byte equals the host byte for that whole time.
- R6: Busy is high from the accepting edge for RD cycles on a load. On a store it is high for any turnaround cycles plus max(WE, ceil(85/T)) cycles (9 at T=10).
- R7: On a load, the inbound byte is registered on the last cycle of the output-enable phase. `rvalid_o` is high for exactly one cycle, the cycle after that edge, and `rdata_o` then holds the byte.
- R8: After output enable rises, the drive enable stays low for at least ceil(35/T) cycles (4 at T=10). A store accepted 2 cycles after a load ends waits ceil(35/T)-2 extra cycles, so write enable falls exactly 40 ns after output enable rose.
- R9: A store that follows a store, or that follows reset, starts its write-enable phase at the accepting edge with no extra cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host store byte |
| busy_o | output | 1 | Access in flight; requests ignored |
| rvalid_o | output | 1 | One-cycle pulse: rdata_o holds load result |
| rdata_o | output | DATA_W | Load result |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Outbound byte to data pads |
| mem_dq_oe_o | output | 1 | Drive enable for data pads |
| mem_dq_i | input | DATA_W | Inbound byte from data pads |

## Verification
The bench builds the block with its default parameters: a 10 ns clock and the stated limits. These give phase counts of 9, 8, 9 and 4 cycles, so every rounding step, the store recovery cycle and a non-trivial turnaround wait are all in play. A behavioural memory in the bench returns the complement of the stored byte until both the address and output-enable access times have passed. It also tracks when its pins may still be driven after output enable rises. As a result, an early capture or a premature bus drive shows up as a data mismatch or a contention count. The sweep covers load, store and load-then-store sequences over a range of low addresses and the highest address, plus a request injected while busy.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_WRITE,
    ST_RECOV,
    ST_READ
  } seq_state_e;

  // ns limit -> whole cycles, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_guard.sv
`timescale 1ns/1ps
module sram_seq_guard #(
  parameter int REL_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic clear_o,
  output logic quiet_o
);

  localparam int W = $clog2(REL_CYC + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (arm_i)       cnt_q <= W'(REL_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // drive may start at the coming edge
  assign clear_o = (cnt_q <= W'(1));
  assign quiet_o = (cnt_q == '0);

  generate
    if (REL_CYC > 1) begin : g_chk
      p_arm_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> !clear_o);
    end
  endgenerate

endmodule

// File: rtl/sram_seq_dpath.sv
`timescale 1ns/1ps
module sram_seq_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      dq_o   <= '0;
    end else if (accept_i) begin
      addr_o <= addr_i;
      dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end

  p_rvalid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_o));

endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter int T_CYCLE_NS = 85,
  parameter int T_AA_NS    = 85,
  parameter int T_OE_NS    = 50,
  parameter int T_WP_NS    = 65,
  parameter int T_AW_NS    = 75,
  parameter int T_DS_NS    = 50,
  parameter int T_REL_NS   = 35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int CYC_C = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int RD_C  = max2(max2(CYC_C, ns_to_cyc(T_AA_NS, CLK_NS)),
                              ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int WE_C  = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                              ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int REC_C = (CYC_C > WE_C) ? CYC_C - WE_C : 0;
  localparam int REL_C = ns_to_cyc(T_REL_NS, CLK_NS);
  localparam int TW    = $clog2(max2(RD_C, WE_C) + 1);

  seq_state_e    state_q, state_d;
  logic          accept, tdone, capture, bus_clear, bus_quiet;
  logic          t_load;
  logic [TW-1:0] t_val;

  assign accept  = req_i && (state_q == ST_IDLE);
  assign capture = (state_q == ST_READ) && tdone;
  assign busy_o  = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        if (!wr_i) begin
          state_d = ST_READ;
          t_load  = 1'b1;
          t_val   = TW'(RD_C - 1);
        end else if (bus_clear) begin
          state_d = ST_WRITE;
          t_load  = 1'b1;
          t_val   = TW'(WE_C - 1);
        end else begin
          state_d = ST_GAP;
        end
      end
      ST_GAP: if (bus_clear) begin
        state_d = ST_WRITE;
        t_load  = 1'b1;
        t_val   = TW'(WE_C - 1);
      end
      ST_WRITE: if (tdone) begin
        if (REC_C > 0) begin
          state_d = ST_RECOV;
          t_load  = 1'b1;
          t_val   = TW'((REC_C > 0) ? REC_C - 1 : 0);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RECOV: if (tdone) state_d = ST_IDLE;
      ST_READ:  if (tdone) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: no glitches at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mem_cs_n_o  <= 1'b1;
      mem_we_n_o  <= 1'b1;
      mem_oe_n_o  <= 1'b1;
      mem_dq_oe_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      mem_cs_n_o  <= 1'b0;
      mem_we_n_o  <= (state_d != ST_WRITE);
      mem_oe_n_o  <= (state_d != ST_READ);
      mem_dq_oe_o <= (state_d == ST_WRITE);
    end
  end

  sram_seq_timer #(.W(TW)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (tdone)
  );

  sram_seq_guard #(.REL_CYC(REL_C)) i_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (capture),
    .clear_o (bus_clear),
    .quiet_o (bus_quiet)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .capture_i (capture),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .dq_o      (mem_dq_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  p_cs_held_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cs_n_o |=> !mem_cs_n_o);

  p_no_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mem_addr_o));

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_we_n_o && !mem_oe_n_o));

  p_addr_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !accept) |=> $stable(mem_addr_o));

  p_drive_on_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> mem_dq_oe_o);

  p_drive_off_we_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> !mem_dq_oe_o);

  p_no_clash_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_n_o && bus_quiet));

endmodule

// File: tb/test_sram_seq.sv
`timescale 1ns/1ps
module test_sram_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_CYC  = cyc(85);
  localparam int C_RD   = mx(cyc(85), cyc(50));
  localparam int C_WE   = mx(mx(cyc(65), cyc(75)), cyc(50));
  localparam int C_WTOT = mx(C_WE, C_CYC);
  localparam int C_REL  = cyc(35);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, rvalid, cs_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_o;
  logic [DW-1:0] dq_i = 8'hA5;
  logic [AW-1:0] maddr;

  int checks = 0, fails = 0, clash = 0;
  bit last_rd = 1'b0;

  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];
  realtime t_addr = 0.0, t_oe_fall = 0.0, t_oe_rise = -1000.0;
  realtime t_we_fall = 0.0, t_wd = 0.0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq i_sram_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .rvalid_o(rvalid), .rdata_o(rdata),
    .mem_cs_n_o(cs_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a * 37 + (a >> 8)) ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // memory model: timing stamps
  always @(maddr)        t_addr    = $realtime;
  always @(negedge oe_n) t_oe_fall = $realtime;
  always @(posedge oe_n) t_oe_rise = $realtime;
  always @(negedge we_n) t_we_fall = $realtime;
  always @(dq_o)         t_wd      = $realtime;

  // store on write strobe release; check store timing (R5)
  always @(posedge we_n) if (rst_n) begin
    int wp, ds, aw;
    wp = int'($realtime - t_we_fall);
    ds = int'($realtime - t_wd);
    aw = int'($realtime - t_addr);
    checks++;
    if (cs_n || wp < 65 || ds < 50 || aw < 75) begin
      fails++;
      $display("FAIL R5 store timing actual wp=%0d ds=%0d aw=%0d cs_n=%0d expected wp>=65 ds>=50 aw>=75 cs_n=0",
               wp, ds, aw, cs_n);
    end
    mem[int'(maddr)] = dq_o;
  end

  // model output and contention watch, off the clock edges
  initial begin
    logic [7:0] v;
    #0.5;
    forever begin
      v = mem.exists(int'(maddr)) ? mem[int'(maddr)] : init_val(int'(maddr));
      if (!cs_n && !oe_n && we_n)
        dq_i = (($realtime - t_addr) >= 85.0 && ($realtime - t_oe_fall) >= 50.0) ? v : ~v;
      else
        dq_i = 8'hA5;
      if (rst_n && dq_oe && ((!cs_n && !oe_n && we_n) || ($realtime - t_oe_rise) < 35.0))
        clash++;
      #1;
    end
  end

  task automatic access(input bit w, input int a, input logic [7:0] d, input bit inject);
    int n, nwe, noe, gap, exp_b, abad, dbad, sep;
    logic [7:0] e;
    n = 0; nwe = 0; noe = 0; abad = 0; dbad = 0;
    @(negedge clk);
    if (last_rd) chk("R7 rvalid single pulse", int'(rvalid), 0);
    chk("R2 idle before request", int'(busy), 0);
    req = 1'b1; wr = w; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (busy && n < 100) begin
      n++;
      if (int'(maddr) != a) abad++;
      if (!we_n) begin
        nwe++;
        if (!dq_oe || dq_o != d) dbad++;
      end else if (dq_oe) dbad++;
      if (!oe_n) noe++;
      if (inject && n == 2) begin req = 1'b1; wr = 1'b1; addr = AW'(a + 1); wdata = ~d; end
      if (inject && n == 3) begin req = 1'b0; addr = AW'(a); end
      @(negedge clk);
    end
    gap   = (w && last_rd) ? mx(C_REL - 2, 0) : 0;
    exp_b = w ? gap + C_WTOT : C_RD;
    chk(w ? (last_rd ? "R6 busy store after load" : "R9 busy store no turnaround")
          : "R6 busy load", n, exp_b);
    chk("R4 address held", abad, 0);
    if (w) begin
      chk("R5 write strobe cycles", nwe, C_WE);
      chk("R5 no output enable on store", noe, 0);
      chk("R5 drive and data follow strobe", dbad, 0);
      if (last_rd) begin
        sep = int'(t_we_fall - t_oe_rise);
        chk("R8 turnaround ns", sep, mx(C_REL, 2) * CLK_PERIOD);
      end
      exp_mem[a] = d;
    end else begin
      chk("R3 output enable cycles", noe, C_RD);
      chk("R3 no write strobe on load", nwe, 0);
      chk("R7 rvalid", int'(rvalid), 1);
      e = exp_mem.exists(a) ? exp_mem[a] : init_val(a);
      chk($sformatf("R7 rdata addr %0d", a), int'(rdata), int'(e));
    end
    last_rd = !w;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset cs_n", int'(cs_n), 1);
    chk("R1 reset we_n", int'(we_n), 1);
    chk("R1 reset oe_n", int'(oe_n), 1);
    chk("R1 reset drive", int'(dq_oe), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset rvalid", int'(rvalid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 selected idle cs_n", int'(cs_n), 0);
    chk("R1 selected idle we_n", int'(we_n), 1);
    chk("R1 selected idle oe_n", int'(oe_n), 1);

    // R9: first store after reset needs no turnaround
    access(1'b1, 100, 8'h3C, 1'b0);
    for (int a = 0; a < 16; a++) access(1'b0, a, 8'h00, 1'b0);
    access(1'b0, (1 << AW) - 1, 8'h00, 1'b0);
    for (int a = 0; a < 16; a++) access(1'b1, a, 8'(a * 7 + 3), 1'b0);
    for (int a = 0; a < 16; a++) access(1'b0, a, 8'h00, 1'b0);
    for (int a = 16; a < 32; a++) begin
      access(1'b0, a, 8'h00, 1'b0);
      access(1'b1, a, 8'(~a), 1'b0);
      access(1'b0, a, 8'h00, 1'b0);
    end
    // R2: request raised while busy is ignored
    access(1'b1, 40, 8'hC3, 1'b1);
    access(1'b0, 41, 8'h00, 1'b0);
    access(1'b0, 40, 8'h00, 1'b0);
    access(1'b1, (1 << AW) - 1, 8'hE7, 1'b0);
    access(1'b0, (1 << AW) - 1, 8'h00, 1'b0);
    access(1'b0, 100, 8'h00, 1'b0);
    repeat (6) @(negedge clk);
    chk("R8 bus contention samples", clash, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule